// File: doc/BRIEF.md
# SCSI Block-Move Phase Engine

This block carries out one block-move transfer on an 8-bit SCSI bus. Software loads a 32-bit move word and pulses `start`. The word holds the requested information-transfer phase and the number of bytes to move. The `target_mode` input selects the bus role. As initiator, the engine first checks that the bus is in the requested phase. It then answers each REQ from the target with an ACK, one byte per handshake. As target, it drives the phase lines itself, raises REQ for each byte and waits for the initiator's ACK. Bytes that enter from the bus leave on the `to_mem_*` valid/ready stream. Bytes sent onto the bus come from the `from_mem_*` stream. A down-counter holds the number of bytes still to move.

Two message phases end in a special way. When the initiator sends its last Message-Out byte, ATN drops in the same cycle as that byte's ACK. When the initiator receives its last Message-In byte, ACK stays asserted until the `clr_ack` command. In initiator mode, a wrong phase at start, or a phase change when a REQ arrives, stops the move with a mismatch interrupt. The remaining byte count is kept on `count_left`.

The controller is a single state machine with these states:
- `ST_IDLE`: waits for `start`.
- `ST_I_CHECK`: compares the requested phase with the bus phase.
- `ST_I_WAIT_REQ`: waits for a synchronized REQ. A changed phase here goes back to idle with the interrupt.
- `ST_I_DATA`: exchanges the byte with the memory stream, then raises ACK.
- `ST_I_ACK`: waits for REQ to fall. It then drops ACK and goes back to `ST_I_WAIT_REQ`, or, on the last byte, finishes with a done pulse.
- `ST_T_REQ`: fetches the byte if the target is sending, then raises REQ.
- `ST_T_WAIT_ACK`: waits for a synchronized ACK.
- `ST_T_PUSH`: hands a received byte to memory.
- `ST_T_WAIT_NACK`: waits for ACK to fall, then either loops to `ST_T_REQ` or finishes.

Top module: `scsi_move_engine`

## Requirements
- R1: On `start`, bits [26:24] of `instr` are taken as the phase code (bit 26 MSG, bit 25 C/D, bit 24 I/O) and bits [23:0] as the byte count. `count_left` shows the full 24-bit count in the cycle after the start.
- R2: A start with a count of zero gives a `done` pulse in the next cycle. REQ and ACK are not driven and the engine stays idle.
- R3: In initiator mode, if `bus_phase_in` differs from the requested phase at start, `mismatch_irq` pulses for one cycle. No ACK is driven and `count_left` keeps the loaded count.
- R4: In initiator mode, each synchronized REQ is answered with ACK once the byte has moved. ACK falls after REQ falls. With I/O=1, bytes go from `bus_data_in` to the memory stream. With I/O=0, bytes go from the memory stream to `bus_data_out`, with `bus_data_oe` high.
- R5: In target mode, `bus_phase_out` carries the phase code and `bus_phase_oe` is high while the move runs. REQ rises only when the synchronized ACK is low. With I/O=1 the target sends bytes from memory. With I/O=0 it receives bytes into memory.
- R6: `count_left` drops by exactly one per byte moved and reads 0 after a complete move.
- R7: `done` is a one-cycle pulse, given once the final handshake has ended and the engine is idle again.
- R8: In an initiator Message-Out move (code 110) with ATN set by `set_atn`, ATN stays high for the earlier bytes. It falls in the same cycle that ACK rises for the final byte.
- R9: In an initiator Message-In move (code 111), ACK stays high after the final byte and after `done`. It falls in the cycle after a `clr_ack` pulse.
- R10: In initiator mode, if a REQ arrives while `bus_phase_in` no longer matches, the engine stops with `mismatch_irq`, drives no ACK for that REQ and leaves the remaining count on `count_left`.
- R11: REQ and ACK inputs pass through a two-flop synchronizer. In initiator mode, ACK rises no earlier than four clock edges after REQ rises (when memory is ready at once).
- R12: After reset, `busy`, `done`, `mismatch_irq`, REQ, ACK, ATN, both output enables and `count_left` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin the move described by `instr` (idle only) |
| instr | input | 32 | Move word: phase code [26:24], byte count [23:0] |
| target_mode | input | 1 | 1 = act as target, 0 = act as initiator |
| set_atn | input | 1 | Raise ATN |
| clr_ack | input | 1 | Release a held ACK (idle only) |
| bus_phase_in | input | 3 | Observed MSG, C/D, I/O lines |
| bus_req_in | input | 1 | REQ from the target (asynchronous) |
| bus_ack_in | input | 1 | ACK from the initiator (asynchronous) |
| bus_data_in | input | DATA_W | Bus data lines as seen |
| bus_phase_out | output | 3 | MSG, C/D, I/O driven in target mode |
| bus_phase_oe | output | 1 | Enable for `bus_phase_out` |
| bus_req_out | output | 1 | REQ driven in target mode |
| bus_ack_out | output | 1 | ACK driven in initiator mode |
| bus_atn_out | output | 1 | ATN line |
| bus_data_out | output | DATA_W | Data driven onto the bus |
| bus_data_oe | output | 1 | Enable for `bus_data_out` |
| to_mem_data | output | DATA_W | Byte toward memory |
| to_mem_valid | output | 1 | `to_mem_data` valid |
| to_mem_ready | input | 1 | Memory accepts the byte |
| from_mem_data | input | DATA_W | Byte from memory |
| from_mem_valid | input | 1 | `from_mem_data` valid |
| from_mem_ready | output | 1 | Engine takes the byte |
| busy | output | 1 | A move is in progress |
| done | output | 1 | One-cycle completion pulse |
| mismatch_irq | output | 1 | One-cycle phase-mismatch pulse |
| count_left | output | CNT_W | Bytes still to move |

## Verification
The bench checks the following corner cases, and what a faulty design would show in each:
- **Final Message-Out byte.** ATN is sampled at every ACK rise. A design that drops ATN one byte early, or holds it past the last byte, shows the wrong ATN level.
- **Message-In end.** ACK is checked after `done`. A design that releases ACK on its own, or ignores `clr_ack`, is caught here.
- **Phase mismatch at start and mid-transfer.** A careless design would answer the stray REQ with an ACK, or would reset or corrupt the residual count.
- **Zero count and REQ latency.** A zero count must finish with no handshake. Counting cycles from REQ to ACK shows whether the synchronizer was bypassed.

// File: rtl/bmv_pkg.sv
package bmv_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_I_CHECK,
        ST_I_WAIT_REQ,
        ST_I_DATA,
        ST_I_ACK,
        ST_T_REQ,
        ST_T_WAIT_ACK,
        ST_T_PUSH,
        ST_T_WAIT_NACK
    } mv_state_e;

    localparam int          PH_LSB     = 24;
    localparam int          PH_W       = 3;
    localparam logic [2:0]  PH_MSG_OUT = 3'b110;
    localparam logic [2:0]  PH_MSG_IN  = 3'b111;

endpackage

// File: rtl/bmv_sync.sv
module bmv_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) stg[0] <= '0;
                else        stg[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/bmv_down_counter.sv
module bmv_down_counter #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] value,
    output logic         is_one,
    output logic         is_zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                   cnt_q <= '0;
        else if (load)                cnt_q <= load_val;
        else if (dec && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign value   = cnt_q;
    assign is_one  = (cnt_q == W'(1));
    assign is_zero = (cnt_q == '0);

    // R6: one byte moved lowers the count by exactly one
    a_r6_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(dec) && !$past(load) && $past(cnt_q) != '0) |-> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/scsi_move_engine.sv
module scsi_move_engine
    import bmv_pkg::*;
#(
    parameter int CNT_W       = 24,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [31:0]       instr,
    input  logic              target_mode,
    input  logic              set_atn,
    input  logic              clr_ack,
    input  logic [2:0]        bus_phase_in,
    input  logic              bus_req_in,
    input  logic              bus_ack_in,
    input  logic [DATA_W-1:0] bus_data_in,
    output logic [2:0]        bus_phase_out,
    output logic              bus_phase_oe,
    output logic              bus_req_out,
    output logic              bus_ack_out,
    output logic              bus_atn_out,
    output logic [DATA_W-1:0] bus_data_out,
    output logic              bus_data_oe,
    output logic [DATA_W-1:0] to_mem_data,
    output logic              to_mem_valid,
    input  logic              to_mem_ready,
    input  logic [DATA_W-1:0] from_mem_data,
    input  logic              from_mem_valid,
    output logic              from_mem_ready,
    output logic              busy,
    output logic              done,
    output logic              mismatch_irq,
    output logic [CNT_W-1:0]  count_left
);
    mv_state_e         state_q, state_d;
    logic [PH_W-1:0]   phase_q, phase_d;
    logic              tgt_q, tgt_d;
    logic [DATA_W-1:0] byte_q, byte_d;
    logic              req_q, req_d, ack_q, ack_d, atn_q, atn_d;
    logic              done_q, done_d, irq_q, irq_d;
    logic              cnt_load, cnt_dec, cnt_one, cnt_zero;
    logic [1:0]        hs_s;
    logic              req_s, ack_s, dir_in;
    logic [31:27]      instr_unused;

    assign instr_unused = instr[31:27];

    bmv_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({bus_ack_in, bus_req_in}), .q(hs_s)
    );
    assign req_s = hs_s[0];
    assign ack_s = hs_s[1];

    bmv_down_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(instr[CNT_W-1:0]),
        .dec(cnt_dec), .value(count_left), .is_one(cnt_one), .is_zero(cnt_zero)
    );

    // inbound = byte travels from bus toward memory
    assign dir_in = tgt_q ? ~phase_q[0] : phase_q[0];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            phase_q <= '0;
            tgt_q   <= 1'b0;
            byte_q  <= '0;
            req_q   <= 1'b0;
            ack_q   <= 1'b0;
            atn_q   <= 1'b0;
            done_q  <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            phase_q <= phase_d;
            tgt_q   <= tgt_d;
            byte_q  <= byte_d;
            req_q   <= req_d;
            ack_q   <= ack_d;
            atn_q   <= atn_d;
            done_q  <= done_d;
            irq_q   <= irq_d;
        end
    end

    // outputs
    always_comb begin
        busy           = (state_q != ST_IDLE);
        to_mem_valid   = (state_q == ST_I_DATA && dir_in) || (state_q == ST_T_PUSH);
        from_mem_ready = (state_q == ST_I_DATA && !dir_in) || (state_q == ST_T_REQ && !dir_in);
        to_mem_data    = byte_q;
        bus_data_out   = byte_q;
        bus_data_oe    = busy && !dir_in;
        bus_phase_out  = phase_q;
        bus_phase_oe   = busy && tgt_q;
        bus_req_out    = req_q;
        bus_ack_out    = ack_q;
        bus_atn_out    = atn_q;
        done           = done_q;
        mismatch_irq   = irq_q;
    end

    // next state
    always_comb begin
        state_d  = state_q;
        phase_d  = phase_q;
        tgt_d    = tgt_q;
        byte_d   = byte_q;
        req_d    = req_q;
        ack_d    = ack_q;
        atn_d    = atn_q | set_atn;
        done_d   = 1'b0;
        irq_d    = 1'b0;
        cnt_load = 1'b0;
        cnt_dec  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (clr_ack) ack_d = 1'b0;
                if (start) begin
                    phase_d  = instr[PH_LSB +: PH_W];
                    tgt_d    = target_mode;
                    cnt_load = 1'b1;
                    if (instr[CNT_W-1:0] == '0) done_d  = 1'b1;
                    else if (target_mode)       state_d = ST_T_REQ;
                    else                        state_d = ST_I_CHECK;
                end
            end
            ST_I_CHECK: begin
                if (bus_phase_in != phase_q) begin
                    irq_d   = 1'b1;
                    state_d = ST_IDLE;
                end else begin
                    state_d = ST_I_WAIT_REQ;
                end
            end
            ST_I_WAIT_REQ: begin
                if (req_s) begin
                    if (bus_phase_in != phase_q) begin
                        irq_d   = 1'b1;
                        state_d = ST_IDLE;
                    end else begin
                        byte_d  = bus_data_in;
                        state_d = ST_I_DATA;
                    end
                end
            end
            ST_I_DATA: begin
                if ((to_mem_valid && to_mem_ready) || (from_mem_ready && from_mem_valid)) begin
                    if (!dir_in) byte_d = from_mem_data;
                    ack_d   = 1'b1;
                    cnt_dec = 1'b1;
                    state_d = ST_I_ACK;
                    if (cnt_one && phase_q == PH_MSG_OUT) atn_d = 1'b0;
                end
            end
            ST_I_ACK: begin
                if (!req_s) begin
                    if (cnt_zero) begin
                        done_d  = 1'b1;
                        state_d = ST_IDLE;
                        if (phase_q != PH_MSG_IN) ack_d = 1'b0;
                    end else begin
                        ack_d   = 1'b0;
                        state_d = ST_I_WAIT_REQ;
                    end
                end
            end
            ST_T_REQ: begin
                if (dir_in) begin
                    req_d   = 1'b1;
                    state_d = ST_T_WAIT_ACK;
                end else if (from_mem_valid) begin
                    byte_d  = from_mem_data;
                    req_d   = 1'b1;
                    state_d = ST_T_WAIT_ACK;
                end
            end
            ST_T_WAIT_ACK: begin
                if (ack_s) begin
                    if (dir_in) begin
                        byte_d  = bus_data_in;
                        state_d = ST_T_PUSH;
                    end else begin
                        req_d   = 1'b0;
                        cnt_dec = 1'b1;
                        state_d = ST_T_WAIT_NACK;
                    end
                end
            end
            ST_T_PUSH: begin
                if (to_mem_ready) begin
                    req_d   = 1'b0;
                    cnt_dec = 1'b1;
                    state_d = ST_T_WAIT_NACK;
                end
            end
            ST_T_WAIT_NACK: begin
                if (!ack_s) begin
                    if (cnt_zero) begin
                        done_d  = 1'b1;
                        state_d = ST_IDLE;
                    end else begin
                        state_d = ST_T_REQ;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // R11: ACK rises only in answer to a synchronized REQ
    a_r11_ack_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_q) |-> req_s);

    // R5: a new REQ is raised only while the synchronized ACK is low
    a_r5_req_after_ack_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_q) |-> !ack_s);

    // R3 / R10: a mismatch leaves the engine idle with the count untouched
    a_r3_irq_idle_count_kept: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> (state_q == ST_IDLE) && $stable(count_left));

    // R7: completion is reported only once the engine is idle
    a_r7_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (state_q == ST_IDLE) && !req_q);

    // R8: an initiator Message-Out move finishes with ATN released
    a_r8_atn_released: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !tgt_q && phase_q == PH_MSG_OUT && !set_atn) |-> !atn_q);

    // R9: a Message-In move finishes with ACK still asserted
    a_r9_ack_held: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !tgt_q && phase_q == PH_MSG_IN && count_left == '0 && $past(busy)) |-> ack_q);
endmodule

// File: tb/scsi_move_engine_tb.sv
module scsi_move_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] instr = '0;
    logic        target_mode = 1'b0;
    logic        set_atn = 1'b0;
    logic        clr_ack = 1'b0;
    logic [2:0]  bus_phase_in = '0;
    logic        bus_req_in = 1'b0;
    logic        bus_ack_in = 1'b0;
    logic [7:0]  bus_data_in = '0;
    logic [2:0]  bus_phase_out;
    logic        bus_phase_oe, bus_req_out, bus_ack_out, bus_atn_out, bus_data_oe;
    logic [7:0]  bus_data_out, to_mem_data, from_mem_data;
    logic        to_mem_valid, from_mem_ready, busy, done, mismatch_irq;
    logic        to_mem_ready = 1'b1;
    logic        from_mem_valid = 1'b1;
    logic [23:0] count_left;

    always #5 clk = ~clk;

    scsi_move_engine u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .target_mode(target_mode),
        .set_atn(set_atn), .clr_ack(clr_ack), .bus_phase_in(bus_phase_in),
        .bus_req_in(bus_req_in), .bus_ack_in(bus_ack_in), .bus_data_in(bus_data_in),
        .bus_phase_out(bus_phase_out), .bus_phase_oe(bus_phase_oe), .bus_req_out(bus_req_out),
        .bus_ack_out(bus_ack_out), .bus_atn_out(bus_atn_out), .bus_data_out(bus_data_out),
        .bus_data_oe(bus_data_oe), .to_mem_data(to_mem_data), .to_mem_valid(to_mem_valid),
        .to_mem_ready(to_mem_ready), .from_mem_data(from_mem_data),
        .from_mem_valid(from_mem_valid), .from_mem_ready(from_mem_ready), .busy(busy),
        .done(done), .mismatch_irq(mismatch_irq), .count_left(count_left)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int done_seen = 0;
    int irq_seen  = 0;
    int src_idx = 0;
    bit src_pend = 1'b0;
    logic [2:0] src_seed = '0;
    int sink_n = 0;
    logic [7:0] sink [256];

    function automatic logic [7:0] pat(input logic [2:0] seed, input int i);
        return 8'(int'(seed) * 37 + i * 5 + 3);
    endfunction

    int src_base = 0;
    assign from_mem_data = pat(src_seed, src_idx - src_base);

    always @(negedge clk) begin
        if (done)         done_seen++;
        if (mismatch_irq) irq_seen++;
        if (src_pend) src_idx++;
        src_pend = from_mem_valid && from_mem_ready;
        if (to_mem_valid && to_mem_ready) begin
            sink[sink_n[7:0]] = to_mem_data;
            sink_n++;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic line(input int which);
        return (which == 0) ? bus_ack_out : bus_req_out;
    endfunction

    task automatic wait_line(input int which, input logic val, input string req);
        int k = 0;
        while (line(which) !== val && k < 60) begin
            @(negedge clk);
            k++;
        end
        if (k >= 60) chk(req, {31'b0, line(which)}, {31'b0, val}, "handshake timeout");
    endtask

    task automatic wait_done(input int d0, input string req);
        int k = 0;
        while (done_seen == d0 && k < 40) begin
            @(negedge clk);
            k++;
        end
        chk(req, done_seen - d0, 1, "done pulse count");
    endtask

    task automatic launch(input logic tgt, input logic [2:0] ph, input logic [23:0] cnt, input logic [2:0] seed);
        @(negedge clk);
        src_seed = seed;
        src_base = src_idx;
        sink_n = 0;
        instr = {5'b0, ph, cnt};
        target_mode = tgt;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R1", count_left, cnt, "loaded count");
    endtask

    // bench acts as target toward an initiator-mode engine
    task automatic peer_init(input int n, input bit dut_in, input bit msgin, input logic [2:0] seed, input bit atn_chk);
        for (int i = 0; i < n; i++) begin
            if (dut_in) bus_data_in = pat(seed, i);
            @(negedge clk);
            bus_req_in = 1'b1;
            wait_line(0, 1'b1, "R4");
            if (atn_chk) chk("R8", bus_atn_out, (i < n - 1), "ATN at ACK rise");
            if (!dut_in) begin
                chk("R4", bus_data_out, pat(seed, i), "byte on bus");
                chk("R4", bus_data_oe, 1, "data enable");
            end
            @(negedge clk);
            bus_req_in = 1'b0;
            if (!(msgin && i == n - 1)) wait_line(0, 1'b0, "R4");
        end
    endtask

    // bench acts as initiator toward a target-mode engine
    task automatic peer_tgt(input int n, input bit dut_sends, input logic [2:0] ph, input logic [2:0] seed);
        for (int i = 0; i < n; i++) begin
            wait_line(1, 1'b1, "R5");
            if (i == 0) begin
                chk("R5", bus_phase_out, ph, "driven phase");
                chk("R5", bus_phase_oe, 1, "phase enable");
            end
            if (dut_sends) chk("R5", bus_data_out, pat(seed, i), "target byte");
            else           bus_data_in = pat(seed, i);
            @(negedge clk);
            bus_ack_in = 1'b1;
            wait_line(1, 1'b0, "R5");
            @(negedge clk);
            bus_ack_in = 1'b0;
        end
    endtask

    // {target, phase[2:0], count[7:0], mismatch, seed[2:0]}
    localparam logic [15:0] VECS [10] = '{
        {1'b0, 3'b001, 8'd4, 1'b0, 3'd1},
        {1'b0, 3'b000, 8'd3, 1'b0, 3'd2},
        {1'b0, 3'b010, 8'd5, 1'b0, 3'd3},
        {1'b0, 3'b011, 8'd1, 1'b0, 3'd4},
        {1'b1, 3'b000, 8'd5, 1'b0, 3'd5},
        {1'b1, 3'b001, 8'd4, 1'b0, 3'd6},
        {1'b1, 3'b111, 8'd2, 1'b0, 3'd7},
        {1'b1, 3'b010, 8'd3, 1'b0, 3'd0},
        {1'b0, 3'b001, 8'd3, 1'b1, 3'd1},
        {1'b0, 3'b100, 8'd2, 1'b0, 3'd2}
    };

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int d0, i0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk("R12", busy, 0, "busy");
        chk("R12", {bus_req_out, bus_ack_out, bus_atn_out}, 0, "REQ/ACK/ATN");
        chk("R12", {bus_phase_oe, bus_data_oe, done, mismatch_irq}, 0, "enables and pulses");
        chk("R12", count_left, 0, "count");

        foreach (VECS[v]) begin
            logic       tgt  = VECS[v][15];
            logic [2:0] ph   = VECS[v][14:12];
            logic [7:0] cnt  = VECS[v][11:4];
            logic       bad  = VECS[v][3];
            logic [2:0] seed = VECS[v][2:0];
            logic       din  = tgt ? ~ph[0] : ph[0];
            bus_phase_in = bad ? (ph ^ 3'b010) : ph;
            d0 = done_seen;
            i0 = irq_seen;
            launch(tgt, ph, {16'b0, cnt}, seed);
            if (bad) begin
                repeat (4) @(negedge clk);
                chk("R3", irq_seen - i0, 1, "mismatch pulse");
                chk("R3", done_seen - d0, 0, "no done");
                chk("R3", count_left, {16'b0, cnt}, "count kept");
                chk("R3", bus_ack_out, 0, "no ACK");
            end else begin
                if (tgt) peer_tgt(int'(cnt), !din, ph, seed);
                else     peer_init(int'(cnt), din, 1'b0, seed, 1'b0);
                wait_done(d0, "R7");
                chk("R6", count_left, 0, "count exhausted");
                chk("R7", busy, 0, "idle after done");
                if (din) begin
                    chk(tgt ? "R5" : "R4", sink_n, int'(cnt), "bytes to memory");
                    for (int i = 0; i < int'(cnt); i++)
                        chk(tgt ? "R5" : "R4", sink[i], pat(seed, i), "memory byte");
                end
            end
        end

        // R2 zero count
        d0 = done_seen;
        @(negedge clk);
        instr = {5'b0, 3'b001, 24'd0};
        target_mode = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2", done, 1, "done next cycle");
        repeat (3) @(negedge clk);
        chk("R2", done_seen - d0, 1, "single done");
        chk("R2", {busy, bus_req_out, bus_ack_out}, 0, "no bus activity");

        // R1 full-width count with mismatch (R3)
        i0 = irq_seen;
        bus_phase_in = 3'b001;
        launch(1'b0, 3'b000, 24'hABCDE1, 3'd0);
        repeat (3) @(negedge clk);
        chk("R3", irq_seen - i0, 1, "mismatch pulse wide");
        chk("R1", count_left, 24'hABCDE1, "wide count kept");

        // R11 synchronizer latency
        bus_phase_in = 3'b000;
        d0 = done_seen;
        launch(1'b0, 3'b000, 24'd1, 3'd4);
        repeat (2) @(negedge clk);
        bus_req_in = 1'b1;
        repeat (3) @(negedge clk);
        chk("R11", bus_ack_out, 0, "no ACK after 3 edges");
        @(negedge clk);
        chk("R11", bus_ack_out, 1, "ACK after 4 edges");
        bus_req_in = 1'b0;
        wait_line(0, 1'b0, "R11");
        wait_done(d0, "R11");

        // R8 ATN release on final Message-Out byte
        @(negedge clk);
        set_atn = 1'b1;
        @(negedge clk);
        set_atn = 1'b0;
        chk("R8", bus_atn_out, 1, "ATN set");
        bus_phase_in = 3'b110;
        d0 = done_seen;
        launch(1'b0, 3'b110, 24'd3, 3'd5);
        peer_init(3, 1'b0, 1'b0, 3'd5, 1'b1);
        wait_done(d0, "R8");
        chk("R8", bus_atn_out, 0, "ATN low after move");

        // R9 ACK held after Message-In
        bus_phase_in = 3'b111;
        d0 = done_seen;
        launch(1'b0, 3'b111, 24'd2, 3'd6);
        peer_init(2, 1'b1, 1'b1, 3'd6, 1'b0);
        wait_done(d0, "R9");
        repeat (5) @(negedge clk);
        chk("R9", bus_ack_out, 1, "ACK still held");
        chk("R9", sink[1], pat(3'd6, 1), "last message byte");
        clr_ack = 1'b1;
        @(negedge clk);
        clr_ack = 1'b0;
        chk("R9", bus_ack_out, 0, "ACK released");

        // R10 phase change mid-transfer
        bus_phase_in = 3'b001;
        i0 = irq_seen;
        d0 = done_seen;
        launch(1'b0, 3'b001, 24'd4, 3'd3);
        peer_init(2, 1'b1, 1'b0, 3'd3, 1'b0);
        bus_phase_in = 3'b011;
        @(negedge clk);
        bus_req_in = 1'b1;
        repeat (6) @(negedge clk);
        chk("R10", irq_seen - i0, 1, "mismatch pulse");
        chk("R10", bus_ack_out, 0, "REQ not answered");
        chk("R10", count_left, 2, "residual count");
        chk("R10", done_seen - d0, 0, "no done");
        bus_req_in = 1'b0;

        repeat (4) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule